// File: doc/BRIEF.md
# Banked Aperture Address Mapper

This block turns a host access inside a 64 KB aperture into a full video memory address. The upper address bits come from a bank number taken from an 8-bit bank control byte. The low 16 bits are the aperture offset, passed through unchanged. A mode input chooses the bank scheme. In shared mode one bank number serves both reads and writes. In split mode reads and writes take separate bank numbers. In split mode the read bank number is assembled from two non-adjacent groups of bits in the control byte.

A two-bit size input gives the memory fitted: 256 KB, 512 KB or 1 MB. Bank bits above that size are dropped, so an address past the end wraps back into the memory. The address and a qualified read or write strobe are registered on the clock edge that samples a host strobe. The memory controller therefore sees them one cycle after the host request. When no strobe is present the last address is held.

Top module: `bankwin_mapper`

## Requirements
- R1: The write bank number is control byte bits 4..1, with bit 4 as the most significant bit. It is used for every write, in both modes.
- R2: With `dual_mode`=1, a read uses the read bank number {bit 0, bit 7, bit 6, bit 5} of the control byte. Bit 0 is the most significant bit and bit 5 the least.
- R3: With `dual_mode`=0, a read uses the write bank number of R1.
- R4: `mem_addr` is the bank number times 65536 plus `host_off`. This means `mem_addr[15:0]` equals the offset and `mem_addr[19:16]` equals the bank number.
- R5: The size code is 0 for 256 KB, 1 for 512 KB, and 2 or 3 for 1 MB. The bank number is reduced modulo 4, 8 or 16 to match, so bits of `mem_addr` above the memory size are zero.
- R6: Address and strobes appear on the rising clock edge that samples `host_rd` or `host_wr`, which is one cycle of latency. The outputs keep their previous values until that edge.
- R7: When `host_rd` and `host_wr` are both high, the access is taken as a write. `mem_wr` is 1, `mem_rd` is 0, and the write bank is used.
- R8: In a cycle with neither strobe, `mem_addr` keeps its value and both `mem_rd` and `mem_wr` are 0 on the following cycle.
- R9: While `rst_n` is low, `mem_addr`, `mem_rd` and `mem_wr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_reg | input | 8 | Bank control byte |
| dual_mode | input | 1 | 1 = separate read and write banks, 0 = shared bank |
| mem_size | input | 2 | Memory size code (0: 256 KB, 1: 512 KB, 2/3: 1 MB) |
| host_off | input | 16 | Offset within the host aperture |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| mem_addr | output | 20 | Video memory byte address |
| mem_rd | output | 1 | Registered read strobe |
| mem_wr | output | 1 | Registered write strobe |

## Verification
The assertions assume the control byte, mode, size and offset are stable and known at each clock edge where a strobe is sampled. The bank checks rely on those inputs as they were in the previous cycle. The bench meets this by changing all inputs only on the falling edge and keeping them fixed across the rising edge that samples them. The bench also covers the cases the properties leave open: both strobes high together, every size code, and a read bank whose top bit comes from the low end of the control byte.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned BANK_W  = 4;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned ADDR_W  = OFF_W + BANK_W;

  typedef enum logic [1:0] {
    MSZ_256K = 2'd0,
    MSZ_512K = 2'd1,
    MSZ_1M   = 2'd2,
    MSZ_1M_B = 2'd3
  } msz_e;

  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/bank_select.sv
module bank_select
  import bankwin_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              dual,
  input  logic              is_write,
  output bank_t             bank
);
  bank_t wr_bank;
  bank_t rd_bank;

  always_comb begin
    wr_bank = ctrl[BANK_W:1];
    rd_bank = {ctrl[0], ctrl[CTRL_W-1:CTRL_W-3]};
    if (is_write || !dual) bank = wr_bank;
    else                   bank = rd_bank;
  end
endmodule

// File: rtl/bank_wrap.sv
module bank_wrap
  import bankwin_pkg::*;
(
  input  bank_t       bank_in,
  input  logic [1:0]  size_code,
  output bank_t       bank_out
);
  localparam int unsigned MIN_BITS = 2;
  int unsigned keep_bits;

  always_comb begin
    unique case (msz_e'(size_code))
      MSZ_256K: keep_bits = MIN_BITS;
      MSZ_512K: keep_bits = MIN_BITS + 1;
      default:  keep_bits = BANK_W;
    endcase
  end

  for (genvar gi = 0; gi < BANK_W; gi++) begin : g_bit
    assign bank_out[gi] = bank_in[gi] & (gi < keep_bits);
  end
endmodule

// File: rtl/bankwin_mapper.sv
module bankwin_mapper
  import bankwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] bank_reg,
  input  logic              dual_mode,
  input  logic [1:0]        mem_size,
  input  logic [OFF_W-1:0]  host_off,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr
);
  bank_t             sel_bank;
  bank_t             eff_bank;
  logic              acc_en;
  logic [ADDR_W-1:0] addr_d;
  logic              rd_d;
  logic              wr_d;

  bank_select u_sel (
    .ctrl     (bank_reg),
    .dual     (dual_mode),
    .is_write (host_wr),
    .bank     (sel_bank)
  );

  bank_wrap u_wrap (
    .bank_in   (sel_bank),
    .size_code (mem_size),
    .bank_out  (eff_bank)
  );

  always_comb begin
    acc_en = host_rd | host_wr;
    addr_d = {eff_bank, host_off};
    wr_d   = host_wr;
    rd_d   = host_rd & ~host_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
    end else if (acc_en) begin
      mem_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      mem_rd <= rd_d;
      mem_wr <= wr_d;
    end
  end
endmodule

// File: rtl/bankwin_mapper_chk.sv
module bankwin_mapper_chk
  import bankwin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] bank_reg,
  input logic [1:0]        mem_size,
  input logic [OFF_W-1:0]  host_off,
  input logic              host_rd,
  input logic              host_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr
);
  a_r6_wr_next: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> mem_wr);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && !host_wr) |=> ($stable(mem_addr) && !mem_rd && !mem_wr));

  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) |=> (mem_addr[OFF_W-1:0] == $past(host_off)));

  a_r5_small_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && mem_size == 2'd0) |=> (mem_addr[ADDR_W-1:OFF_W+2] == '0));

  a_r1_write_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && mem_size[1]) |=> (mem_addr[ADDR_W-1:OFF_W] == $past(bank_reg[BANK_W:1])));
endmodule

bind bankwin_mapper bankwin_mapper_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bank_reg (bank_reg),
  .mem_size (mem_size),
  .host_off (host_off),
  .host_rd  (host_rd),
  .host_wr  (host_wr),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/bankwin_mapper_tb_top.sv
module bankwin_mapper_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bank_reg;
  logic        dual_mode;
  logic [1:0]  mem_size;
  logic [15:0] host_off;
  logic        host_rd;
  logic        host_wr;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;

  int n_chk;
  int n_err;

  bankwin_mapper dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_reg  (bank_reg),
    .dual_mode (dual_mode),
    .mem_size  (mem_size),
    .host_off  (host_off),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {ctrl, dual, size, offset, rd, wr, expected address}
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {8'h1E, 1'b0, 2'd2, 16'h1234, 1'b0, 1'b1, 20'hF1234},  // R1 R4
    {8'hA1, 1'b1, 2'd3, 16'hBEEF, 1'b1, 1'b0, 20'hDBEEF},  // R2
    {8'hA1, 1'b1, 2'd3, 16'h0001, 1'b0, 1'b1, 20'h00001},  // R1 split mode
    {8'hA1, 1'b0, 2'd2, 16'h00FF, 1'b1, 1'b0, 20'h000FF},  // R3
    {8'h0C, 1'b0, 2'd2, 16'h8000, 1'b1, 1'b0, 20'h68000},  // R3
    {8'h6F, 1'b1, 2'd1, 16'h4000, 1'b1, 1'b0, 20'h34000},  // R5 512K
    {8'h6F, 1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b1, 20'h3FFFF},  // R5 256K
    {8'h1E, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 20'h30000},  // R5 256K
    {8'h1E, 1'b0, 2'd1, 16'h0000, 1'b0, 1'b1, 20'h70000},  // R5 512K
    {8'h6F, 1'b1, 2'd2, 16'h0010, 1'b1, 1'b1, 20'h70010},  // R7
    {8'h80, 1'b1, 2'd2, 16'hFFFF, 1'b1, 1'b0, 20'h4FFFF}   // R2
  };

  task automatic check(input string tag, input logic [19:0] ea,
                       input logic er, input logic ew);
    n_chk++;
    if (mem_addr !== ea || mem_rd !== er || mem_wr !== ew) begin
      n_err++;
      $display("FAIL %s: addr=%h rd=%b wr=%b expected addr=%h rd=%b wr=%b",
               tag, mem_addr, mem_rd, mem_wr, ea, er, ew);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic d, input logic [1:0] s,
                       input logic [15:0] o, input logic r, input logic w);
    bank_reg  = c;
    dual_mode = d;
    mem_size  = s;
    host_off  = o;
    host_rd   = r;
    host_wr   = w;
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    drive(8'hFF, 1'b1, 2'd3, 16'hFFFF, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", 20'h0, 1'b0, 1'b0);
    drive(8'h00, 1'b0, 2'd2, 16'h0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][48:41], VEC[i][40], VEC[i][39:38], VEC[i][37:22],
            VEC[i][21], VEC[i][20]);
      @(negedge clk);
      check($sformatf("R4 vector %0d", i), VEC[i][19:0],
            VEC[i][21] & ~VEC[i][20], VEC[i][20]);
    end

    // R8: idle cycle with changed inputs holds address, drops strobes
    drive(8'h33, 1'b1, 2'd3, 16'h5555, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 idle hold", 20'h4FFFF, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 idle hold 2", 20'h4FFFF, 1'b0, 1'b0);

    // R6: before the sampling edge the outputs are unchanged
    drive(8'h1E, 1'b0, 2'd3, 16'hA5A5, 1'b0, 1'b1);
    #1;
    check("R6 before edge", 20'h4FFFF, 1'b0, 1'b0);
    @(negedge clk);
    check("R6 after edge", 20'hFA5A5, 1'b0, 1'b1);

    // R3: split read bank ignored in shared mode even with read bits set
    drive(8'hE3, 1'b0, 2'd3, 16'h0042, 1'b1, 1'b0);
    @(negedge clk);
    check("R3 shared read", 20'h10042, 1'b1, 1'b0);

    // R9: reset during operation
    rst_n = 1'b0;
    #1;
    check("R9 mid reset", 20'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00, 1'b0, 2'd2, 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 after release idle", 20'h0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule